// File: doc/BRIEF.md
# Address-Window Trace Gate

This block decides, one clock at a time, whether instruction trace should be captured for the access being presented. It holds a bank of programmable address comparators. Each comparator has an address value and a three-bit access-kind code. Neighbouring comparators (even index as lower bound, the odd index above it as upper bound) form address windows. Each window can be switched in on its own, and one global mode bit says whether a window hit admits trace (include) or blocks it (exclude).

A start/stop latch can also gate the result. Single comparators, marked in a start mask, switch trace on. Others, marked in a stop mask, switch it off. The final decision is ANDed with an enable event from an external event unit and registered, so the decision for an access appears one cycle after that access is presented. Configuration is loaded through a plain indexed register write port.

Top module: `trace_window_filter`

## Requirements
- R1: While reset is high and after it is released, trace_enable_o is 0, the start/stop latch is clear and every configuration register is zero (include mode, no window enabled, so nothing is traced until configured).
- R2: Write index i (0..7) loads comparator i's address value, index 8+i loads comparator i's kind code, index 16 loads the start/stop register and index 17 loads the control register; a write takes effect for accesses presented from the next cycle on.
- R3: trace_enable_o is registered: it reflects the access, kind and event presented in the previous cycle.
- R4: When trace_event_i is 0, trace_enable_o is 0 in the following cycle regardless of any other setting.
- R5: Window n spans comparators 2n (lower) and 2n+1 (upper) and is enabled by control bit n; it hits when the access kind equals comparator 2n's kind code. In include mode (control bit 24 = 0) trace passes only if some enabled window hits, so with no window enabled nothing is traced.
- R6: In exclude mode (control bit 24 = 1) trace passes only if no enabled window hits; with no window enabled every access passes.
- R7: A window contains its lower bound and excludes its upper bound: an address equal to the lower value hits, an address equal to the upper value does not.
- R8: Only the low 3 bits of a kind write are kept (0x99 gives code 1, instruction fetch; 0x9C gives code 4, data access). A comparator matches only an access of its own kind, and code 7 (also the idle access kind) never matches.
- R9: With control bit 25 set, trace also requires the start/stop latch. Bits [7:0] of the start/stop register mark start comparators and bits [23:16] mark stop comparators; a comparator fires when the address equals its value and the kind matches. A start sets the latch and the starting access itself is traced; a stop clears it and the stopping access is not traced.
- R10: If a start and a stop comparator fire in the same cycle, the latch is cleared.
- R11: With control bit 25 clear, the latch state has no effect on trace_enable_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | 5 | Configuration register index |
| cfg_wr_data | input | 32 | Configuration write data |
| fetch_addr_i | input | 32 | Address of the presented access |
| fetch_kind_i | input | 3 | Kind of the presented access (7 = idle) |
| trace_event_i | input | 1 | Enable event from the event unit |
| trace_enable_o | output | 1 | Registered trace enable decision |

## Verification
The bench probes both window edges, since a design using an inclusive upper bound or an exclusive lower bound would trace one address too many or too few. It presents a start and a stop on the same comparator to catch a latch where start takes priority and trace would stay on. It flips between include and exclude with no window enabled, where an inverted default would either trace everything or nothing. It also feeds a kind mismatch and the code-7 idle kind, which a design comparing the whole kind register or ignoring kinds would wrongly admit.

// File: rtl/twf_pkg.sv
package twf_pkg;
  localparam int EXCL_BIT  = 24;
  localparam int SSEN_BIT  = 25;
  localparam int STOP_LSB  = 16;
  localparam int KIND_W    = 3;
endpackage

// File: rtl/twf_regfile.sv
module twf_regfile
  import twf_pkg::*;
#(
  parameter int NUM_CMP = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]     cmp_val_o,
  output logic [NUM_CMP-1:0][KIND_W-1:0]     cmp_kind_o,
  output logic [NUM_CMP-1:0]                 start_mask_o,
  output logic [NUM_CMP-1:0]                 stop_mask_o,
  output logic [NUM_CMP/2-1:0]               pair_en_o,
  output logic                               excl_o,
  output logic                               ss_en_o
);
  localparam int NUM_PAIR = NUM_CMP / 2;
  localparam int SS_IDX   = 2 * NUM_CMP;
  localparam int CTRL_IDX = 2 * NUM_CMP + 1;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_regs
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_val_o[i]  <= '0;
        cmp_kind_o[i] <= '0;
      end else if (wr_en) begin
        if (wr_idx == IDX_W'(i))
          cmp_val_o[i] <= wr_data[ADDR_W-1:0];
        if (wr_idx == IDX_W'(NUM_CMP + i))
          cmp_kind_o[i] <= wr_data[KIND_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_mask_o <= '0;
      stop_mask_o  <= '0;
      pair_en_o    <= '0;
      excl_o       <= 1'b0;
      ss_en_o      <= 1'b0;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(SS_IDX)) begin
        start_mask_o <= wr_data[NUM_CMP-1:0];
        stop_mask_o  <= wr_data[STOP_LSB +: NUM_CMP];
      end
      if (wr_idx == IDX_W'(CTRL_IDX)) begin
        pair_en_o <= wr_data[NUM_PAIR-1:0];
        excl_o    <= wr_data[EXCL_BIT];
        ss_en_o   <= wr_data[SSEN_BIT];
      end
    end
  end
endmodule

// File: rtl/twf_cmp.sv
module twf_cmp
  import twf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [ADDR_W-1:0] val_i,
  input  logic [KIND_W-1:0] cmp_kind_i,
  output logic              eq_o,
  output logic              ge_o,
  output logic              kind_ok_o
);
  // Code all-ones is reserved: it marks idle and never matches.
  assign kind_ok_o = (kind_i == cmp_kind_i) && (cmp_kind_i != '1);
  assign ge_o      = (addr_i >= val_i);
  assign eq_o      = (addr_i == val_i) && kind_ok_o;
endmodule

// File: rtl/twf_gate.sv
module twf_gate #(
  parameter int NUM_CMP = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 event_i,
  input  logic [NUM_CMP-1:0]   eq_hit_i,
  input  logic [NUM_CMP-1:0]   ge_i,
  input  logic [NUM_CMP-1:0]   kind_ok_i,
  input  logic [NUM_CMP/2-1:0] pair_en_i,
  input  logic                 excl_i,
  input  logic                 ss_en_i,
  input  logic [NUM_CMP-1:0]   start_mask_i,
  input  logic [NUM_CMP-1:0]   stop_mask_i,
  output logic                 trace_enable_o,
  output logic                 ss_state_o
);
  localparam int NUM_PAIR = NUM_CMP / 2;

  logic [NUM_PAIR-1:0] win_hit;
  logic                any_hit;
  logic                range_ok;
  logic                start_fire;
  logic                stop_fire;
  logic                ss_next;

  for (genvar n = 0; n < NUM_PAIR; n++) begin : g_win
    assign win_hit[n] = pair_en_i[n] & kind_ok_i[2*n]
                      & ge_i[2*n] & ~ge_i[2*n+1];
  end

  assign any_hit    = |win_hit;
  assign range_ok   = excl_i ? ~any_hit : any_hit;
  assign start_fire = |(eq_hit_i & start_mask_i);
  assign stop_fire  = |(eq_hit_i & stop_mask_i);

  always_comb begin
    ss_next = ss_state_o;
    if (start_fire) ss_next = 1'b1;
    if (stop_fire)  ss_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_state_o     <= 1'b0;
      trace_enable_o <= 1'b0;
    end else begin
      ss_state_o     <= ss_next;
      trace_enable_o <= event_i & range_ok & (~ss_en_i | ss_next);
    end
  end
endmodule

// File: rtl/trace_window_filter.sv
module trace_window_filter
  import twf_pkg::*;
#(
  parameter int NUM_CMP = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_wr_en,
  input  logic [$clog2(2*NUM_CMP+2)-1:0]    cfg_wr_idx,
  input  logic [DATA_W-1:0]                 cfg_wr_data,
  input  logic [ADDR_W-1:0]                 fetch_addr_i,
  input  logic [KIND_W-1:0]                 fetch_kind_i,
  input  logic                              trace_event_i,
  output logic                              trace_enable_o
);
  localparam int IDX_W    = $clog2(2*NUM_CMP+2);
  localparam int NUM_PAIR = NUM_CMP / 2;

  logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_val;
  logic [NUM_CMP-1:0][KIND_W-1:0] cmp_kind;
  logic [NUM_CMP-1:0]             start_mask;
  logic [NUM_CMP-1:0]             stop_mask;
  logic [NUM_PAIR-1:0]            pair_en;
  logic                           excl;
  logic                           ss_en;
  logic [NUM_CMP-1:0]             eq_hit;
  logic [NUM_CMP-1:0]             ge;
  logic [NUM_CMP-1:0]             kind_ok;
  logic                           ss_state;

  twf_regfile #(
    .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
    .cmp_val_o(cmp_val), .cmp_kind_o(cmp_kind),
    .start_mask_o(start_mask), .stop_mask_o(stop_mask),
    .pair_en_o(pair_en), .excl_o(excl), .ss_en_o(ss_en)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    twf_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .addr_i(fetch_addr_i), .kind_i(fetch_kind_i),
      .val_i(cmp_val[i]), .cmp_kind_i(cmp_kind[i]),
      .eq_o(eq_hit[i]), .ge_o(ge[i]), .kind_ok_o(kind_ok[i])
    );
  end

  twf_gate #(.NUM_CMP(NUM_CMP)) u_gate (
    .clk(clk), .rst(rst), .event_i(trace_event_i),
    .eq_hit_i(eq_hit), .ge_i(ge), .kind_ok_i(kind_ok),
    .pair_en_i(pair_en), .excl_i(excl), .ss_en_i(ss_en),
    .start_mask_i(start_mask), .stop_mask_i(stop_mask),
    .trace_enable_o(trace_enable_o), .ss_state_o(ss_state)
  );
endmodule

// File: rtl/twf_checker.sv
module twf_checker #(
  parameter int NUM_CMP = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 event_i,
  input logic                 trace_enable_o,
  input logic [NUM_CMP/2-1:0] pair_en,
  input logic                 excl,
  input logic                 ss_en,
  input logic [NUM_CMP-1:0]   start_mask,
  input logic [NUM_CMP-1:0]   stop_mask,
  input logic [NUM_CMP-1:0]   eq_hit,
  input logic                 ss_state
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!trace_enable_o && !ss_state));

  p_event_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !event_i |=> !trace_enable_o);

  p_include_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (!excl && pair_en == '0) |=> !trace_enable_o);

  p_exclude_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (event_i && excl && pair_en == '0 && !ss_en) |=> trace_enable_o);

  p_latch_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (ss_en && !ss_state && (eq_hit & start_mask) == '0) |=> !trace_enable_o);

  p_stop_wins_r10: assert property (@(posedge clk) disable iff (rst)
    ((eq_hit & stop_mask) != '0) |=> !ss_state);
endmodule

bind trace_window_filter twf_checker #(.NUM_CMP(NUM_CMP)) u_twf_checker (
  .clk(clk), .rst(rst), .event_i(trace_event_i),
  .trace_enable_o(trace_enable_o), .pair_en(pair_en), .excl(excl),
  .ss_en(ss_en), .start_mask(start_mask), .stop_mask(stop_mask),
  .eq_hit(eq_hit), .ss_state(ss_state)
);

// File: tb/trace_window_filter_bench.sv
module trace_window_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] fetch_addr_i = '0;
  logic [2:0]  fetch_kind_i = 3'd7;
  logic        trace_event_i = 1'b0;
  logic        trace_enable_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_window_filter u_trace_window_filter (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .fetch_addr_i(fetch_addr_i),
    .fetch_kind_i(fetch_kind_i), .trace_event_i(trace_event_i),
    .trace_enable_o(trace_enable_o)
  );

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s trace_enable got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    @(negedge clk);
    fetch_kind_i  = 3'd7;
    trace_event_i = 1'b0;
    cfg_wr_en     = 1'b1;
    cfg_wr_idx    = 5'(idx);
    cfg_wr_data   = data;
    @(negedge clk);
    cfg_wr_en     = 1'b0;
  endtask

  task automatic present(input logic [31:0] a, input logic [2:0] k,
                         input bit ev, input bit exp, input string req);
    @(negedge clk);
    fetch_addr_i  = a;
    fetch_kind_i  = k;
    trace_event_i = ev;
    @(negedge clk);
    check(trace_enable_o, exp, req);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(trace_enable_o, 1'b0, "R1 during reset");
    rst = 1'b0;
    present(32'h1000, 3'd1, 1'b1, 1'b0, "R1 include with no window");
  endtask

  task automatic t_event_and_latency();
    wr(17, 32'h0100_0000);
    @(negedge clk);
    fetch_addr_i = 32'h20; fetch_kind_i = 3'd1; trace_event_i = 1'b1;
    #1 check(trace_enable_o, 1'b0, "R3 not before the edge");
    @(negedge clk);
    check(trace_enable_o, 1'b1, "R3/R6 exclude with no window");
    present(32'h20, 3'd1, 1'b0, 1'b0, "R4 event low");
    present(32'h20, 3'd1, 1'b1, 1'b1, "R6 event back high");
  endtask

  task automatic t_include_window();
    wr(0, 32'h1000);
    wr(1, 32'h2000);
    wr(8, 32'h99);
    wr(17, 32'h1);
    present(32'h1000, 3'd1, 1'b1, 1'b1, "R7 lower bound");
    present(32'h1FFC, 3'd1, 1'b1, 1'b1, "R5 inside window");
    present(32'h2000, 3'd1, 1'b1, 1'b0, "R7 upper bound");
    present(32'h0FFF, 3'd1, 1'b1, 1'b0, "R5 below window");
    present(32'h1500, 3'd4, 1'b1, 1'b0, "R8 kind mismatch");
    wr(8, 32'h9F);
    present(32'h1500, 3'd7, 1'b1, 1'b0, "R8 code 7 never matches");
    wr(8, 32'h99);
    wr(17, 32'h0);
    present(32'h1500, 3'd1, 1'b1, 1'b0, "R5 window disabled");
  endtask

  task automatic t_exclude_window();
    wr(17, 32'h0100_0001);
    present(32'h1500, 3'd1, 1'b1, 1'b0, "R6 excluded hit");
    present(32'h3000, 3'd1, 1'b1, 1'b1, "R6 outside excluded window");
  endtask

  task automatic t_two_windows();
    wr(4, 32'h8000);
    wr(5, 32'h9000);
    wr(12, 32'h9C);
    wr(17, 32'h5);
    present(32'h8800, 3'd4, 1'b1, 1'b1, "R5 second window data kind");
    present(32'h8800, 3'd1, 1'b1, 1'b0, "R8 second window fetch kind");
    present(32'h1800, 3'd1, 1'b1, 1'b1, "R2 first window still active");
  endtask

  task automatic t_start_stop();
    wr(3, 32'h4000);
    wr(11, 32'h99);
    wr(6, 32'h5000);
    wr(14, 32'h99);
    wr(16, 32'h0040_0008);
    wr(17, 32'h0300_0000);
    present(32'h0100, 3'd1, 1'b1, 1'b0, "R9 latch clear");
    present(32'h4000, 3'd4, 1'b1, 1'b0, "R9 start kind mismatch");
    present(32'h4000, 3'd1, 1'b1, 1'b1, "R9 start access traced");
    present(32'h4100, 3'd1, 1'b1, 1'b1, "R9 latch held");
    present(32'h5000, 3'd1, 1'b1, 1'b0, "R9 stop access not traced");
    present(32'h5100, 3'd1, 1'b1, 1'b0, "R9 latch cleared");
  endtask

  task automatic t_stop_wins();
    wr(7, 32'h6000);
    wr(15, 32'h99);
    wr(16, 32'h00C0_0088);
    present(32'h4000, 3'd1, 1'b1, 1'b1, "R10 start first");
    present(32'h6000, 3'd1, 1'b1, 1'b0, "R10 start and stop together");
    present(32'h4100, 3'd1, 1'b1, 1'b0, "R10 latch left clear");
  endtask

  task automatic t_latch_ignored();
    wr(17, 32'h0100_0000);
    present(32'h4100, 3'd1, 1'b1, 1'b1, "R11 latch ignored when gate off");
  endtask

  initial begin
    t_reset();
    t_event_and_latency();
    t_include_window();
    t_exclude_window();
    t_two_windows();
    t_start_stop();
    t_stop_wins();
    t_latch_ignored();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule